// File: doc/BRIEF.md
# Time-Sliced Cell Balancing Controller

This block drives the passive balance switches of a stack of up to fifteen series cells. Three banks of five enable bits hold the host's balancing choice: bank index 0 covers cells 1 to 5, index 1 covers cells 6 to 10 and index 2 covers cells 11 to 15. Bit k of a bank's data is the lowest-numbered cell of that bank plus k. Each cell has one balance output. An output is high only if its stored bit is set, the cell is not part of a forbidden adjacent pair, and the current frame is not in its measurement slot.

A frame scheduler counts a 1 ms tick through 250-tick frames. It has two states. `SLOT_MEASURE` covers ticks 0 to 74 and is the reset state. `SLOT_BALANCE` covers ticks 75 to 249. The scheduler moves from `SLOT_MEASURE` to `SLOT_BALANCE` on the tick that takes the count from 74 to 75. It moves back on the tick that wraps the count from 249 to 0. While the measurement flag is high, every output is held low in `SLOT_MEASURE`. Two event pulses clear all stored bits and the violation flag: a device-ready fault and a wake from ship mode into normal mode. After either event the host must write the banks again.

Top module: `cell_balancer`

## Requirements
- R1: After synchronous reset, every stored bit, every balance output, the violation flag and every readback value are zero, and the scheduler is in `SLOT_MEASURE` at count 0.
- R2: A write with `wr_bank` 0, 1 or 2 replaces the five bits of that bank, where data bit k maps to cell 5*bank+k+1. A write with `wr_bank` 3 changes nothing. `rd_data` returns the stored bits of the bank named by `rd_bank`, and returns zero for index 3.
- R3: Outside a blanking slot, and with no adjacent pair stored, `bal_out` bit n-1 equals the stored bit of cell n for any number of non-adjacent cells.
- R4: Cells n and n+1 are an adjacent pair when both are set and both lie in the same group of five. For every such pair, the outputs of both cells are forced low and `adj_viol` goes high in the same cycle. Other cells keep driving, and readback still shows the stored bits.
- R5: Cells 5 and 6, or cells 10 and 11, set together are not a violation, and both of them drive.
- R6: Once `adj_viol` is high, it stays high until reset or a clearing event, even after the host writes a legal pattern.
- R7: While `meas_en` is 1, all outputs are low at frame counts 0 to 74 and follow R3/R4 at counts 75 to 249. The count advances once per `tick_1ms` pulse and wraps from 249 to 0.
- R8: While `meas_en` is 0, no blanking is applied at any frame count.
- R9: A `xready_evt` pulse clears all stored bits and `adj_viol` at the next clock edge.
- R10: A `wake_evt` pulse clears all stored bits and `adj_viol` at the next clock edge.
- R11: When a clearing event and a bank write arrive in the same cycle, the clear wins and the written bits are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bank write strobe |
| wr_bank | input | 2 | Bank index for the write |
| wr_data | input | 5 | Enable bits to store in the bank |
| rd_bank | input | 2 | Bank index for readback |
| rd_data | output | 5 | Stored bits of the selected bank |
| meas_en | input | 1 | Enables the measurement blanking slot |
| tick_1ms | input | 1 | One-cycle frame tick pulse |
| xready_evt | input | 1 | Device-ready fault event pulse |
| wake_evt | input | 1 | Ship-to-normal wake event pulse |
| bal_out | output | 15 | Gated balance drive, bit n-1 for cell n |
| adj_viol | output | 1 | Sticky adjacent-pair violation flag |

## Verification
The bench stores cell pairs on both sides of the 5/6 and 10/11 boundaries. A checker that wrongly spans groups would suppress those pairs and raise a false violation. It writes runs of three adjacent cells and a single pair at the top of a group, so a suppressor that drops only one cell of a pair, or that masks too many cells, shows up on `bal_out`. It walks a full frame with ticks and checks counts 74, 75, 249 and the wrap, which catches an off-by-one in slot length or wrap point. It also fires a wake event together with a write, which exposes a design that lets the host write win.

// File: rtl/cbal_pkg.sv
package cbal_pkg;
    typedef enum logic {
        SLOT_MEASURE = 1'b0,
        SLOT_BALANCE = 1'b1
    } slot_e;
endpackage

// File: rtl/cbal_frame_sched.sv
module cbal_frame_sched
    import cbal_pkg::*;
#(
    parameter int FRAME_TICKS = 250,
    parameter int BLANK_TICKS = 75
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic meas_en,
    output logic blank
);
    localparam int CW = $clog2(FRAME_TICKS);
    localparam logic [CW-1:0] LAST_CNT  = CW'(FRAME_TICKS - 1);
    localparam logic [CW-1:0] BLANK_END = CW'(BLANK_TICKS - 1);

    logic [CW-1:0] cnt_q;
    slot_e         state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_MEASURE: if (tick && cnt_q == BLANK_END) state_d = SLOT_BALANCE;
            SLOT_BALANCE: if (tick && cnt_q == LAST_CNT)  state_d = SLOT_MEASURE;
            default:      state_d = SLOT_MEASURE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SLOT_MEASURE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SLOT_MEASURE: blank = meas_en;
            SLOT_BALANCE: blank = 1'b0;
            default:      blank = meas_en;
        endcase
    end

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_CNT);
    // R7
    slot_align_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_BALANCE) == (cnt_q > BLANK_END));
    // R8
    blank_gate_chk: assert property (@(posedge clk) disable iff (rst)
        blank |-> meas_en);
endmodule

// File: rtl/cbal_reg_bank.sv
module cbal_reg_bank #(
    parameter int GROUPS = 3,
    parameter int GW     = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        wr_en,
    input  logic [$clog2(GROUPS)-1:0]   wr_bank,
    input  logic [GW-1:0]               wr_data,
    input  logic [$clog2(GROUPS)-1:0]   rd_bank,
    output logic [GW-1:0]               rd_data,
    output logic [GROUPS*GW-1:0]        bits
);
    localparam int BW = $clog2(GROUPS);

    for (genvar g = 0; g < GROUPS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                bits[g*GW +: GW] <= '0;
            end else if (wr_en && wr_bank == BW'(g)) begin
                bits[g*GW +: GW] <= wr_data;
            end
        end

        // R2
        wr_land_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !clr && wr_bank == BW'(g)) |=> bits[g*GW +: GW] == $past(wr_data));
    end

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (rd_bank == BW'(g)) rd_data = bits[g*GW +: GW];
        end
    end

    // R2
    oob_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr && int'(wr_bank) >= GROUPS) |=> $stable(bits));
    // R11
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> bits == '0);
endmodule

// File: rtl/cbal_adj_check.sv
module cbal_adj_check #(
    parameter int GROUPS = 3,
    parameter int GW     = 5
) (
    input  logic [GROUPS*GW-1:0] bits,
    output logic [GROUPS*GW-1:0] suppress,
    output logic                 any_pair
);
    localparam int PPG = GW - 1;
    localparam int NP  = GROUPS * PPG;

    logic [NP-1:0] pair;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar i = 0; i < PPG; i++) begin : g_pair
            assign pair[g*PPG + i] = bits[g*GW + i] & bits[g*GW + i + 1];
        end
        for (genvar c = 0; c < GW; c++) begin : g_cell
            if (c == 0) begin : g_lo
                assign suppress[g*GW + c] = pair[g*PPG + c];
            end else if (c == GW - 1) begin : g_hi
                assign suppress[g*GW + c] = pair[g*PPG + c - 1];
            end else begin : g_mid
                assign suppress[g*GW + c] = pair[g*PPG + c - 1] | pair[g*PPG + c];
            end
        end
    end

    assign any_pair = |pair;
endmodule

// File: rtl/cell_balancer.sv
module cell_balancer #(
    parameter int GROUPS      = 3,
    parameter int GW          = 5,
    parameter int FRAME_TICKS = 250,
    parameter int BLANK_TICKS = 75
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [$clog2(GROUPS)-1:0]   wr_bank,
    input  logic [GW-1:0]               wr_data,
    input  logic [$clog2(GROUPS)-1:0]   rd_bank,
    output logic [GW-1:0]               rd_data,
    input  logic                        meas_en,
    input  logic                        tick_1ms,
    input  logic                        xready_evt,
    input  logic                        wake_evt,
    output logic [GROUPS*GW-1:0]        bal_out,
    output logic                        adj_viol
);
    localparam int NCELL = GROUPS * GW;

    logic             clr;
    logic [NCELL-1:0] bits;
    logic [NCELL-1:0] suppress;
    logic             pair_now;
    logic             blank;
    logic             sticky_q;

    assign clr = xready_evt | wake_evt;

    cbal_reg_bank #(.GROUPS(GROUPS), .GW(GW)) u_bank (
        .clk(clk), .rst(rst), .clr(clr),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_data(wr_data),
        .rd_bank(rd_bank), .rd_data(rd_data), .bits(bits)
    );

    cbal_adj_check #(.GROUPS(GROUPS), .GW(GW)) u_adj (
        .bits(bits), .suppress(suppress), .any_pair(pair_now)
    );

    cbal_frame_sched #(.FRAME_TICKS(FRAME_TICKS), .BLANK_TICKS(BLANK_TICKS)) u_sched (
        .clk(clk), .rst(rst), .tick(tick_1ms), .meas_en(meas_en), .blank(blank)
    );

    always_ff @(posedge clk) begin
        if (rst || clr)    sticky_q <= 1'b0;
        else if (pair_now) sticky_q <= 1'b1;
    end

    assign adj_viol = sticky_q | pair_now;
    assign bal_out  = blank ? '0 : (bits & ~suppress);

    for (genvar g = 0; g < GROUPS; g++) begin : g_out_chk
        // R4
        out_no_pair_chk: assert property (@(posedge clk) disable iff (rst)
            (bal_out[g*GW +: GW-1] & bal_out[g*GW+1 +: GW-1]) == '0);
    end

    // R6
    viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (adj_viol && !clr) |=> adj_viol);
    // R9
    evt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!adj_viol && bal_out == '0));
    // R3
    out_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (bal_out & ~bits) == '0);
endmodule

// File: tb/cell_balancer_tb.sv
module cell_balancer_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_bank = '0;
    logic [4:0]  wr_data = '0;
    logic [1:0]  rd_bank = '0;
    logic [4:0]  rd_data;
    logic        meas_en = 1'b0;
    logic        tick_1ms = 1'b0;
    logic        xready_evt = 1'b0;
    logic        wake_evt = 1'b0;
    logic [14:0] bal_out;
    logic        adj_viol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [14:0] bal;
        logic        viol;
        logic [4:0]  rd;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    cell_balancer u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_data(wr_data),
        .rd_bank(rd_bank), .rd_data(rd_data), .meas_en(meas_en), .tick_1ms(tick_1ms),
        .xready_evt(xready_evt), .wake_evt(wake_evt), .bal_out(bal_out), .adj_viol(adj_viol)
    );

    // Monitor: compares a quarter period after each edge
    always @(posedge clk) begin
        #(CLK_P/4);
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (bal_out !== e.bal || adj_viol !== e.viol || rd_data !== e.rd) begin
                errors++;
                $display("FAIL %s: bal=%h viol=%b rd=%b expected bal=%h viol=%b rd=%b",
                         e.tag, bal_out, adj_viol, rd_data, e.bal, e.viol, e.rd);
            end
        end
    end

    task automatic step(input logic w, input logic [1:0] b, input logic [4:0] d,
                        input logic x, input logic wk, input logic t);
        @(negedge clk);
        wr_en = w; wr_bank = b; wr_data = d;
        xready_evt = x; wake_evt = wk; tick_1ms = t;
        @(negedge clk);
        wr_en = 1'b0; xready_evt = 1'b0; wake_evt = 1'b0; tick_1ms = 1'b0;
    endtask

    task automatic wr(input logic [1:0] b, input logic [4:0] d);
        step(1'b1, b, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic expect_item(input logic [14:0] bal, input logic viol,
                               input logic [1:0] rb, input logic [4:0] rd, input string tag);
        exp_t e;
        rd_bank = rb;
        e.bal = bal; e.viol = viol; e.rd = rd; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        expect_item(15'h0000, 1'b0, 2'd0, 5'b00000, "R1 reset state");
        expect_item(15'h0000, 1'b0, 2'd2, 5'b00000, "R1 reset bank2");

        wr(2'd0, 5'b10101);
        expect_item(15'h0015, 1'b0, 2'd0, 5'b10101, "R2 R3 bank0 cells 1,3,5");
        wr(2'd1, 5'b01010);
        expect_item(15'h0155, 1'b0, 2'd1, 5'b01010, "R3 bank1 cells 7,9");
        wr(2'd2, 5'b10001);
        expect_item(15'h4555, 1'b0, 2'd2, 5'b10001, "R3 bank2 cells 11,15");
        wr(2'd3, 5'b11111);
        expect_item(15'h4555, 1'b0, 2'd0, 5'b10101, "R2 bank3 write ignored");
        expect_item(15'h4555, 1'b0, 2'd3, 5'b00000, "R2 bank3 readback zero");

        wr(2'd0, 5'b10000);
        wr(2'd1, 5'b01001);
        expect_item(15'h4530, 1'b0, 2'd1, 5'b01001, "R5 cells 5,6 across boundary");
        wr(2'd1, 5'b10001);
        expect_item(15'h4630, 1'b0, 2'd1, 5'b10001, "R5 cells 10,11 across boundary");

        wr(2'd2, 5'b00111);
        expect_item(15'h0230, 1'b1, 2'd2, 5'b00111, "R4 run 11-13 suppressed");
        wr(2'd0, 5'b11010);
        expect_item(15'h0222, 1'b1, 2'd0, 5'b11010, "R4 pair 4-5 suppressed, cell 2 drives");

        wr(2'd2, 5'b00100);
        wr(2'd0, 5'b00010);
        expect_item(15'h1222, 1'b1, 2'd0, 5'b00010, "R6 flag sticky after legal rewrite");

        step(1'b0, 2'd0, 5'b0, 1'b1, 1'b0, 1'b0);
        expect_item(15'h0000, 1'b0, 2'd1, 5'b00000, "R9 xready clears");

        wr(2'd1, 5'b00101);
        expect_item(15'h00A0, 1'b0, 2'd1, 5'b00101, "R3 rewrite after clear");
        step(1'b1, 2'd0, 5'b00001, 1'b0, 1'b1, 1'b0);
        expect_item(15'h0000, 1'b0, 2'd0, 5'b00000, "R10 R11 wake beats write");

        wr(2'd1, 5'b00011);
        expect_item(15'h0000, 1'b1, 2'd1, 5'b00011, "R4 pair 6-7");
        step(1'b0, 2'd0, 5'b0, 1'b0, 1'b1, 1'b0);
        expect_item(15'h0000, 1'b0, 2'd1, 5'b00000, "R10 wake clears flag");

        do_reset();
        meas_en = 1'b1;
        wr(2'd0, 5'b00101);
        expect_item(15'h0000, 1'b0, 2'd0, 5'b00101, "R7 blank at count 0");
        for (int i = 0; i < 74; i++) step(1'b0, 2'd0, 5'b0, 1'b0, 1'b0, 1'b1);
        expect_item(15'h0000, 1'b0, 2'd0, 5'b00101, "R7 blank at count 74");
        step(1'b0, 2'd0, 5'b0, 1'b0, 1'b0, 1'b1);
        expect_item(15'h0005, 1'b0, 2'd0, 5'b00101, "R7 drive at count 75");
        for (int i = 0; i < 174; i++) step(1'b0, 2'd0, 5'b0, 1'b0, 1'b0, 1'b1);
        expect_item(15'h0005, 1'b0, 2'd0, 5'b00101, "R7 drive at count 249");
        step(1'b0, 2'd0, 5'b0, 1'b0, 1'b0, 1'b1);
        expect_item(15'h0000, 1'b0, 2'd0, 5'b00101, "R7 blank after wrap");
        meas_en = 1'b0;
        expect_item(15'h0005, 1'b0, 2'd0, 5'b00101, "R8 no blank when meas_en low");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule